// File: doc/BRIEF.md
# Vector Length Setting Unit

This block owns the active vector length of a vector unit. When a set-length instruction arrives it takes the application's requested element count and the current maximum vector length. It computes how many elements the next stripmined pass should process, stores that count and returns it as the instruction result. When the request lies between one and two times the maximum, the request is halved instead of clamped. The last two passes of a stripmined loop then carry nearly equal work.

A reconfiguration strobe loads the stored length with the maximum vector length. A type-change-only strobe leaves the length alone. Every cycle the block also produces a per-element tail mask. The mask flags the elements whose index is at or above the active length and below the maximum, and a downstream datapath zeroes those elements in the destination. The maximum vector length comes in on an input. Decode and the datapath sit outside this block.

Top module: `vlen_unit`

## Requirements
- R1: When set_i is high, cfg_wr_i is low and avl_i <= mvl_i, vl_o equals avl_i after the next rising clock edge.
- R2: When set_i is high, cfg_wr_i is low and mvl_i < avl_i < 2*mvl_i, vl_o equals avl_i/2 rounded down after the next edge.
- R3: When set_i is high, cfg_wr_i is low and avl_i >= 2*mvl_i, vl_o equals mvl_i after the next edge. This covers a request with every bit set, and the comparison is made without overflow even for the largest avl_i.
- R4: rd_o is loaded with the newly computed length, zero-extended to XLEN bits, on the same edge as vl_o. It keeps its value on every cycle that does not perform a set.
- R5: When cfg_wr_i is high, vl_o is loaded with mvl_i on the next edge. This takes priority over a simultaneous set_i, and in that case rd_o is unchanged.
- R6: A cycle with type_wr_i high and both set_i and cfg_wr_i low leaves vl_o unchanged.
- R7: After each edge, bit i of tail_o is 1 exactly when the new vl_o is non-zero and vl_o <= i < mvl_i, where mvl_i is the value sampled at that edge. When vl_o is 0, tail_o is all zeros.
- R8: Synchronous active-high reset clears vl_o, rd_o and tail_o to zero.
- R9: After any set or reconfiguration, vl_o lies between 0 and the sampled mvl_i, inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avl_i | input | XLEN | Requested application length, unsigned |
| mvl_i | input | LW | Current maximum vector length (at most NELEM) |
| set_i | input | 1 | Set-length instruction strobe |
| cfg_wr_i | input | 1 | Register configuration write strobe |
| type_wr_i | input | 1 | Element-type-only change strobe |
| vl_o | output | LW | Stored active vector length |
| rd_o | output | XLEN | Value returned to the destination register |
| tail_o | output | NELEM | Per-element tail flags |

## Verification
Requests are placed just under, at and just over the maximum, and at twice the maximum, both under and at it. These tell the pass-through, halving and clamping regions apart, and each boundary is checked on the side where an off-by-one in a comparator would show. An all-ones request and a zero maximum test overflow of the doubled comparison and the empty case. A zero request confirms that the tail mask stays empty. Colliding strobes (reconfigure with set, type change alone) separate the priority order. A long random run against the behavioural model then covers changing maximum values between sets, where the mask must follow the new maximum while the stored length holds.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  typedef enum logic [1:0] {
    UPD_HOLD = 2'd0,
    UPD_SET  = 2'd1,
    UPD_CFG  = 2'd2
  } upd_kind_t;
endpackage

// File: rtl/vlen_ctrl.sv
module vlen_ctrl
  import vlen_pkg::*;
(
  input  logic      set_i,
  input  logic      cfg_wr_i,
  input  logic      type_wr_i,
  output upd_kind_t kind_o
);
  // Reconfiguration dominates; a type-only change never touches the length.
  always_comb begin
    if (cfg_wr_i)
      kind_o = UPD_CFG;
    else if (set_i)
      kind_o = UPD_SET;
    else if (type_wr_i)
      kind_o = UPD_HOLD;
    else
      kind_o = UPD_HOLD;
  end
endmodule

// File: rtl/vlen_pick.sv
module vlen_pick #(
  parameter int XLEN = 32,
  parameter int LW   = 7
) (
  input  logic [XLEN-1:0] avl_i,
  input  logic [LW-1:0]   mvl_i,
  output logic [LW-1:0]   vl_o
);
  // Compare width: wide enough for the request and for twice the maximum.
  localparam int CW = (XLEN > LW + 1) ? XLEN : LW + 1;

  logic [CW-1:0] avl_x;
  logic [CW-1:0] mvl_x;
  logic [CW-1:0] twice_x;
  logic [CW-1:0] half_x;
  logic          ge_twice;
  logic          gt_max;

  assign avl_x    = CW'(avl_i);
  assign mvl_x    = CW'(mvl_i);
  assign twice_x  = mvl_x << 1;
  assign half_x   = avl_x >> 1;
  assign ge_twice = (avl_x >= twice_x);
  assign gt_max   = (avl_x > mvl_x);

  always_comb begin
    if (ge_twice)
      vl_o = mvl_i;
    else if (gt_max)
      vl_o = LW'(half_x);
    else
      vl_o = LW'(avl_x);
  end
endmodule

// File: rtl/vlen_reg.sv
module vlen_reg
  import vlen_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int LW   = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  upd_kind_t       kind_i,
  input  logic [LW-1:0]   pick_i,
  input  logic [LW-1:0]   mvl_i,
  output logic [LW-1:0]   vl_next_o,
  output logic [LW-1:0]   vl_o,
  output logic [XLEN-1:0] rd_o
);
  logic [LW-1:0]   vl_q;
  logic [XLEN-1:0] rd_q;

  always_comb begin
    case (kind_i)
      UPD_CFG: vl_next_o = mvl_i;
      UPD_SET: vl_next_o = pick_i;
      default: vl_next_o = vl_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q <= '0;
      rd_q <= '0;
    end else begin
      vl_q <= vl_next_o;
      if (kind_i == UPD_SET)
        rd_q <= XLEN'(pick_i);
    end
  end

  assign vl_o = vl_q;
  assign rd_o = rd_q;

  // R5: reconfiguration loads the maximum
  a_r5_cfg_load: assert property (@(posedge clk) disable iff (rst)
    (kind_i == UPD_CFG) |=> (vl_q == $past(mvl_i)));

  // R6: hold cycles keep the length
  a_r6_type_hold: assert property (@(posedge clk) disable iff (rst)
    (kind_i == UPD_HOLD) |=> $stable(vl_q));

  // R4: returned value matches the stored length after a set
  a_r4_rd_match: assert property (@(posedge clk) disable iff (rst)
    (kind_i == UPD_SET) |=> (rd_q == XLEN'(vl_q)));

  // R4: returned value is held when no set happens
  a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (kind_i != UPD_SET) |=> $stable(rd_q));

  // R9: stored length never above the sampled maximum after an update
  a_r9_vl_bound: assert property (@(posedge clk) disable iff (rst)
    (kind_i != UPD_HOLD) |=> (vl_q <= $past(mvl_i)));
endmodule

// File: rtl/vlen_tail.sv
module vlen_tail #(
  parameter int NELEM = 64,
  parameter int LW    = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LW-1:0]    vl_i,
  input  logic [LW-1:0]    mvl_i,
  output logic [NELEM-1:0] tail_o
);
  logic [NELEM-1:0] mask_d;
  logic [NELEM-1:0] mask_q;
  logic             any_active;

  assign any_active = (vl_i != '0);

  for (genvar g = 0; g < NELEM; g++) begin : g_elem
    localparam logic [LW-1:0] IDX = LW'(g);
    assign mask_d[g] = any_active && (IDX >= vl_i) && (IDX < mvl_i);
  end

  always_ff @(posedge clk) begin
    if (rst)
      mask_q <= '0;
    else
      mask_q <= mask_d;
  end

  assign tail_o = mask_q;

  // R7: number of flagged elements equals the gap between maximum and length
  a_r7_tail_count: assert property (@(posedge clk) disable iff (rst)
    ($past(vl_i) != '0 && $past(mvl_i) >= $past(vl_i) && $past(mvl_i) <= LW'(NELEM))
    |-> ($countones(mask_q) == int'($past(mvl_i)) - int'($past(vl_i))));
endmodule

// File: rtl/vlen_unit.sv
module vlen_unit
  import vlen_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NELEM = 64,
  parameter int LW    = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  avl_i,
  input  logic [LW-1:0]    mvl_i,
  input  logic             set_i,
  input  logic             cfg_wr_i,
  input  logic             type_wr_i,
  output logic [LW-1:0]    vl_o,
  output logic [XLEN-1:0]  rd_o,
  output logic [NELEM-1:0] tail_o
);
  upd_kind_t     kind;
  logic [LW-1:0] pick;
  logic [LW-1:0] vl_next;

  vlen_ctrl u_ctrl (
    .set_i     (set_i),
    .cfg_wr_i  (cfg_wr_i),
    .type_wr_i (type_wr_i),
    .kind_o    (kind)
  );

  vlen_pick #(.XLEN(XLEN), .LW(LW)) u_pick (
    .avl_i (avl_i),
    .mvl_i (mvl_i),
    .vl_o  (pick)
  );

  vlen_reg #(.XLEN(XLEN), .LW(LW)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .kind_i    (kind),
    .pick_i    (pick),
    .mvl_i     (mvl_i),
    .vl_next_o (vl_next),
    .vl_o      (vl_o),
    .rd_o      (rd_o)
  );

  vlen_tail #(.NELEM(NELEM), .LW(LW)) u_tail (
    .clk    (clk),
    .rst    (rst),
    .vl_i   (vl_next),
    .mvl_i  (mvl_i),
    .tail_o (tail_o)
  );

  // R7: empty length flags nothing
  a_r7_empty_mask: assert property (@(posedge clk) disable iff (rst)
    (vl_o == '0) |-> (tail_o == '0));

  // R3: a full-ones request clamps to the maximum
  a_r3_all_ones: assert property (@(posedge clk) disable iff (rst)
    (set_i && !cfg_wr_i && (avl_i == '1)) |=> (vl_o == $past(mvl_i)));
endmodule

// File: tb/sim_vlen_unit.sv
`timescale 1ns/1ps
module sim_vlen_unit;
  localparam int XLEN  = 32;
  localparam int NELEM = 64;
  localparam int LW    = $clog2(NELEM + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [XLEN-1:0]  avl = '0;
  logic [LW-1:0]    mvl = '0;
  logic             set_s = 1'b0;
  logic             cfg_s = 1'b0;
  logic             typ_s = 1'b0;
  logic [LW-1:0]    vl_o;
  logic [XLEN-1:0]  rd_o;
  logic [NELEM-1:0] tail_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  longint m_vl = 0;
  longint m_rd = 0;
  logic [NELEM-1:0] m_tail = '0;

  always #2 clk = ~clk;

  vlen_unit #(.XLEN(XLEN), .NELEM(NELEM)) u0 (
    .clk(clk), .rst(rst), .avl_i(avl), .mvl_i(mvl),
    .set_i(set_s), .cfg_wr_i(cfg_s), .type_wr_i(typ_s),
    .vl_o(vl_o), .rd_o(rd_o), .tail_o(tail_o)
  );

  function automatic longint pick_len(longint a, longint m);
    if (a >= 2 * m) return m;
    else if (a > m) return a / 2;
    else return a;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_mask(string tag, logic [NELEM-1:0] act, logic [NELEM-1:0] exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of inputs, update the model, compare all outputs.
  task automatic step(string tag, longint a, int m, bit s, bit c, bit t);
    @(negedge clk);
    avl = XLEN'(a); mvl = LW'(m); set_s = s; cfg_s = c; typ_s = t;
    @(posedge clk);
    #1;
    if (c) m_vl = m;
    else if (s) begin
      m_vl = pick_len(a, m);
      m_rd = m_vl;
    end
    for (int i = 0; i < NELEM; i++)
      m_tail[i] = (m_vl != 0) && (i >= m_vl) && (i < m);
    chk({tag, " vl"}, longint'(vl_o), m_vl);
    chk({tag, " rd"}, longint'(rd_o), m_rd);
    chk_mask({tag, " tail"}, tail_o, m_tail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset vl", longint'(vl_o), 0);
    chk("R8 reset rd", longint'(rd_o), 0);
    chk_mask("R8 reset tail", tail_o, '0);
    @(negedge clk);
    rst = 1'b0;

    step("R1 below max", 5, 16, 1, 0, 0);
    step("R1 at max", 16, 16, 1, 0, 0);
    step("R2 just above max", 17, 16, 1, 0, 0);
    chk("R2 half of 17", longint'(vl_o), 8);
    step("R2 just below twice", 31, 16, 1, 0, 0);
    chk("R2 half of 31", longint'(vl_o), 15);
    step("R3 at twice", 32, 16, 1, 0, 0);
    chk("R3 clamp at 32", longint'(vl_o), 16);
    step("R3 all ones", 64'hFFFF_FFFF, 16, 1, 0, 0);
    chk("R3 all ones clamp", longint'(vl_o), 16);
    step("R3 all ones big max", 64'hFFFF_FFFF, 64, 1, 0, 0);
    chk("R3 all ones max 64", longint'(vl_o), 64);
    step("R2 max 64", 100, 64, 1, 0, 0);
    chk("R2 half of 100", longint'(vl_o), 50);
    step("R1 zero request", 0, 16, 1, 0, 0);
    chk_mask("R7 zero length no tail", tail_o, '0);
    step("R1 small", 3, 8, 1, 0, 0);
    chk_mask("R7 tail bits 3..7", tail_o, NELEM'(64'h00F8));
    step("R6 type only", 40, 8, 0, 0, 1);
    chk("R6 vl held", longint'(vl_o), 3);
    step("R4 idle hold", 9, 8, 0, 0, 0);
    chk("R4 rd held", longint'(rd_o), 3);
    step("R5 cfg load", 2, 24, 0, 1, 0);
    chk("R5 vl equals max", longint'(vl_o), 24);
    step("R5 cfg beats set", 3, 20, 1, 1, 0);
    chk("R5 vl from cfg", longint'(vl_o), 20);
    chk("R5 rd untouched", longint'(rd_o), 3);
    step("R9 zero max", 64'hFFFF_FFFF, 0, 1, 0, 0);
    chk("R9 zero max gives zero", longint'(vl_o), 0);
    step("R7 max grows, vl held", 0, 30, 0, 0, 0);

    for (int n = 0; n < 400; n++) begin
      int m;
      longint a;
      int sel;
      m = $urandom_range(0, NELEM);
      sel = $urandom_range(0, 3);
      case (sel)
        0: a = $urandom_range(0, 2 * NELEM + 4);
        1: a = longint'($urandom());
        2: a = m + $urandom_range(0, 1);
        default: a = 2 * m - $urandom_range(0, 1);
      endcase
      if (a < 0) a = 0;
      step("R9 random", a, m, ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 3) == 0));
      vectors++;
      if (longint'(vl_o) > m) begin
        if ((set_s || cfg_s)) begin
          errors++;
          $display("FAIL R9 bound actual=%0d expected<=%0d", vl_o, m);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule